// File: doc/BRIEF.md
# SD Four-Lane Data Block CRC Checker

This block watches the four data lines of an SD card bus while the card sends one read block. It waits to be armed by a start pulse. It then finds the start bit, which is a low level on lane 0. After that it takes in 1024 payload nibbles and rebuilds 512 bytes from them, presenting each byte on a one-cycle valid strobe with no backpressure. Each lane has its own bit-serial CRC16 engine, which is fed only the bits that appeared on that lane.

Once the payload is in, the card sends a 16-bit check value on every lane at the same time. The block captures these four values and then takes one further end-bit sample. It then raises done for one cycle, together with a per-lane mismatch vector and a block-level CRC error flag. A controller that sees the error stops the transfer, requests the same block again, and re-arms this block with a new start pulse.

The sequencer has five states:
- IDLE: the block is unarmed.
- HUNT: the block is armed and looks for the start bit.
- DATA: payload nibbles are received.
- CRC: the check bits are received.
- END: the block waits for the end-bit sample.

Transitions:
- start moves any state to HUNT.
- HUNT goes to DATA on a strobe with lane 0 low.
- DATA goes to CRC on the 1024th payload strobe.
- CRC goes to END on the 16th check-bit strobe.
- END goes to IDLE on the next strobe, which also produces done.

Cycles without a strobe never advance the sequencer.

Top module: `sd_lane_crc_checker`

## Requirements
- R1: After synchronous reset, byte_valid, done, crc_err and lane_mismatch are 0. The block stays in IDLE and ignores every strobe until a start pulse arrives.
- R2: A start pulse in any state clears the counters, all lane CRC registers, the captured check values and the status outputs, and arms the block. The cycle after start shows done=0, crc_err=0 and lane_mismatch=0. A strobe in the same cycle as start is ignored.
- R3: While the block is armed, strobes with dat_in[0]=1 are ignored. The first strobe with dat_in[0]=0 is the start bit, and the payload starts with the following strobe.
- R4: Payload nibbles pair into bytes with the high nibble first. byte_data = {first nibble, second nibble}, and byte_valid is high for exactly one cycle, the cycle after the clock edge that sampled the second nibble. A block yields 512 bytes.
- R5: Each lane k (0..3) runs CRC16 with polynomial 0x1021 and a zero start value. It takes the payload bits on that lane in arrival order, which means byte bit k+4 and then byte bit k for every byte in turn.
- R6: The 16 strobes that follow the 1024th payload nibble carry each lane's expected CRC, most significant bit first, on dat_in[k].
- R7: One further strobe, the end bit, is consumed whatever its value. done is high for exactly one cycle, the cycle after the edge that sampled that strobe. Cycles with dat_strobe=0 do not advance the block.
- R8: In the done cycle, lane_mismatch[k]=1 if and only if lane k's computed CRC differs from the received one, and crc_err=1 if and only if any lane mismatches. Both values hold until the next start pulse or reset.
- R9: After done the block returns to IDLE and ignores strobes. A new start pulse, including one after a failed block, lets a following clean block pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that clears the block and arms it for a new block |
| dat_strobe | input | 1 | High in the cycle where dat_in holds a valid bus sample |
| dat_in | input | 4 | Data lane sample, bit k is lane k |
| byte_valid | output | 1 | One-cycle pulse marking a new byte_data |
| byte_data | output | 8 | Reassembled payload byte |
| done | output | 1 | One-cycle pulse once the end bit has been consumed |
| crc_err | output | 1 | Block-level CRC failure, valid from done until the next start |
| lane_mismatch | output | 4 | Per-lane CRC failure flags, valid from done until the next start |

## Verification
On every cycle the assertions check the following:
- byte_valid and done are single-cycle pulses, and each follows a strobe.
- The cycle after reset or after a start pulse is quiet.
- The status outputs change only in a done cycle or when they are cleared.

Other behaviour can only be shown by the bench's scenarios, where a behavioural model is compared cycle by cycle and each block is checked against CRCs computed from the payload. These scenarios cover:
- the byte values and their order;
- the lane-to-bit mapping of the CRC;
- the placement of the check bits and the end bit;
- the exact lane that is flagged;
- abandoning a block in mid-payload;
- recovery after a failed block.

// File: rtl/sdcrc_pkg.sv
package sdcrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_HUNT = 3'd1,
        ST_DATA = 3'd2,
        ST_CRC  = 3'd3,
        ST_END  = 3'd4
    } seq_state_t;

    localparam int          CRC_W    = 16;
    localparam logic [15:0] CRC_POLY = 16'h1021;

    // One message bit into a CRC16 register, MSB-first form.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                  input logic             din);
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sdcrc_seq.sv
module sdcrc_seq
    import sdcrc_pkg::*;
#(
    parameter int NIBBLES  = 1024,
    parameter int CRC_BITS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic strobe,
    input  logic mark,
    output logic clr,
    output logic data_en,
    output logic crc_en,
    output logic fin,
    output logic done
);

    localparam int CNT_MAX = (NIBBLES > CRC_BITS) ? NIBBLES : CRC_BITS;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(NIBBLES - 1);
    localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_BITS - 1);

    seq_state_t       state_q;
    seq_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    logic             data_last;
    logic             crc_last;

    assign take      = strobe && !start;
    assign data_last = (cnt_q == DATA_LAST);
    assign crc_last  = (cnt_q == CRC_LAST);
    assign clr       = rst || start;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (start) begin
            state_d = ST_HUNT;
        end else if (take) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_HUNT: if (!mark)     state_d = ST_DATA;
                ST_DATA: if (data_last) state_d = ST_CRC;
                ST_CRC:  if (crc_last)  state_d = ST_END;
                ST_END:  state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // Per-state enables
    always_comb begin
        data_en = 1'b0;
        crc_en  = 1'b0;
        fin     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_HUNT: ;
            ST_DATA: data_en = take;
            ST_CRC:  crc_en  = take;
            ST_END:  fin     = take;
            default: ;
        endcase
    end

    // Nibble / bit counter shared by DATA and CRC phases
    always_ff @(posedge clk) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (data_en) begin
            cnt_q <= data_last ? '0 : cnt_q + CNT_W'(1);
        end else if (crc_en) begin
            cnt_q <= crc_last ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
        end else begin
            done <= fin;
        end
    end

endmodule

// File: rtl/sdcrc_lane.sv
module sdcrc_lane
    import sdcrc_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic data_en,
    input  logic crc_en,
    input  logic bit_in,
    output logic mismatch
);

    logic [CRC_W-1:0] calc_q;
    logic [CRC_W-1:0] recv_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            calc_q <= '0;
        end else if (data_en) begin
            calc_q <= crc_step(calc_q, bit_in);
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            recv_q <= '0;
        end else if (crc_en) begin
            recv_q <= {recv_q[CRC_W-2:0], bit_in};
        end
    end

    assign mismatch = (calc_q != recv_q);

endmodule

// File: rtl/sdcrc_pack.sv
module sdcrc_pack #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               clr,
    input  logic               data_en,
    input  logic [LANES-1:0]   nib,
    output logic               byte_valid,
    output logic [2*LANES-1:0] byte_data
);

    logic             second_q;
    logic [LANES-1:0] high_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            second_q   <= 1'b0;
            high_q     <= '0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (data_en) begin
                if (!second_q) begin
                    high_q   <= nib;
                    second_q <= 1'b1;
                end else begin
                    byte_data  <= {high_q, nib};
                    byte_valid <= 1'b1;
                    second_q   <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/sd_lane_crc_checker.sv
module sd_lane_crc_checker #(
    parameter int LANES         = 4,
    parameter int PAYLOAD_BYTES = 512
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               dat_strobe,
    input  logic [LANES-1:0]   dat_in,
    output logic               byte_valid,
    output logic [2*LANES-1:0] byte_data,
    output logic               done,
    output logic               crc_err,
    output logic [LANES-1:0]   lane_mismatch
);

    localparam int NIBBLES = PAYLOAD_BYTES * 2;

    logic             clr;
    logic             data_en;
    logic             crc_en;
    logic             fin;
    logic [LANES-1:0] lane_mm;

    sdcrc_seq #(
        .NIBBLES  (NIBBLES),
        .CRC_BITS (sdcrc_pkg::CRC_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .strobe  (dat_strobe),
        .mark    (dat_in[0]),
        .clr     (clr),
        .data_en (data_en),
        .crc_en  (crc_en),
        .fin     (fin),
        .done    (done)
    );

    sdcrc_pack #(
        .LANES (LANES)
    ) u_pack (
        .clk        (clk),
        .clr        (clr),
        .data_en    (data_en),
        .nib        (dat_in),
        .byte_valid (byte_valid),
        .byte_data  (byte_data)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        sdcrc_lane u_lane (
            .clk      (clk),
            .clr      (clr),
            .data_en  (data_en),
            .crc_en   (crc_en),
            .bit_in   (dat_in[k]),
            .mismatch (lane_mm[k])
        );
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            lane_mismatch <= '0;
            crc_err       <= 1'b0;
        end else if (fin) begin
            lane_mismatch <= lane_mm;
            crc_err       <= |lane_mm;
        end
    end

endmodule

// File: rtl/sdcrc_checker.sv
module sdcrc_checker #(
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             dat_strobe,
    input logic             byte_valid,
    input logic             done,
    input logic             crc_err,
    input logic [LANES-1:0] lane_mismatch
);

    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!done && !byte_valid && !crc_err && lane_mismatch == '0));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(start) && !$past(rst)) |-> (!done && !byte_valid && !crc_err && lane_mismatch == '0));

    a_r4_byte_after_strobe: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> $past(dat_strobe));

    a_r4_byte_single: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    a_r7_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(dat_strobe));

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_status_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(start) && !done) |-> ($stable(lane_mismatch) && $stable(crc_err)));

endmodule

bind sd_lane_crc_checker sdcrc_checker #(.LANES(LANES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .dat_strobe    (dat_strobe),
    .byte_valid    (byte_valid),
    .done          (done),
    .crc_err       (crc_err),
    .lane_mismatch (lane_mismatch)
);

// File: tb/sd_lane_crc_checker_bench.sv
module sd_lane_crc_checker_bench;

    localparam int NB = 512;
    localparam int NN = NB * 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       dat_strobe = 1'b0;
    logic [3:0] dat_in = 4'hF;
    logic       byte_valid;
    logic [7:0] byte_data;
    logic       done;
    logic       crc_err;
    logic [3:0] lane_mismatch;

    always #4 clk = ~clk;

    sd_lane_crc_checker u_sd_lane_crc_checker (
        .clk           (clk),
        .rst           (rst),
        .start         (start),
        .dat_strobe    (dat_strobe),
        .dat_in        (dat_in),
        .byte_valid    (byte_valid),
        .byte_data     (byte_data),
        .done          (done),
        .crc_err       (crc_err),
        .lane_mismatch (lane_mismatch)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step(input logic [15:0] c, input logic b);
        if (c[15] ^ b) return {c[14:0], 1'b0} ^ 16'h1021;
        return {c[14:0], 1'b0};
    endfunction

    logic [7:0] pay [NB];

    function automatic logic [15:0] lane_ref(input int k);
        logic [15:0] c = '0;
        for (int i = 0; i < NB; i++) begin
            c = step(c, pay[i][k+4]);
            c = step(c, pay[i][k]);
        end
        return c;
    endfunction

    // Behavioural reference: 0 idle, 1 armed, 2 payload, 3 check bits, 4 end bit
    int          m_state = 0;
    int          m_cnt = 0;
    bit          m_second = 0;
    logic [3:0]  m_hi;
    logic [15:0] m_calc [4];
    logic [15:0] m_recv [4];
    logic        e_bv = 0, e_done = 0, e_err = 0;
    logic [7:0]  e_byte = '0;
    logic [3:0]  e_mm = '0;
    bit          live = 0;

    always @(posedge clk) begin
        live = 1;
        e_bv = 0;
        e_done = 0;
        if (rst || start) begin
            m_state = rst ? 0 : 1;
            m_cnt = 0;
            m_second = 0;
            for (int k = 0; k < 4; k++) begin m_calc[k] = '0; m_recv[k] = '0; end
            e_err = 0;
            e_mm = '0;
        end else if (dat_strobe) begin
            case (m_state)
                1: if (!dat_in[0]) m_state = 2;
                2: begin
                    for (int k = 0; k < 4; k++) m_calc[k] = step(m_calc[k], dat_in[k]);
                    if (!m_second) begin m_hi = dat_in; m_second = 1; end
                    else begin e_byte = {m_hi, dat_in}; e_bv = 1; m_second = 0; end
                    m_cnt++;
                    if (m_cnt == NN) begin m_cnt = 0; m_state = 3; end
                end
                3: begin
                    for (int k = 0; k < 4; k++) m_recv[k] = {m_recv[k][14:0], dat_in[k]};
                    m_cnt++;
                    if (m_cnt == 16) begin m_cnt = 0; m_state = 4; end
                end
                4: begin
                    e_done = 1;
                    for (int k = 0; k < 4; k++) e_mm[k] = (m_calc[k] != m_recv[k]);
                    e_err = |e_mm;
                    m_state = 0;
                end
                default: ;
            endcase
        end
    end

    logic [7:0] rxq [$];
    int         done_cnt = 0;
    int         bv_cnt = 0;
    logic [3:0] got_mm = '0;
    logic       got_err = 0;

    always @(negedge clk) begin
        if (live) begin
            check(byte_valid === e_bv, "R4 byte_valid", byte_valid, e_bv);
            if (e_bv) check(byte_data === e_byte, "R4 byte_data", byte_data, e_byte);
            check(done === e_done, "R7 done", done, e_done);
            check(crc_err === e_err, "R8 crc_err", crc_err, e_err);
            check(lane_mismatch === e_mm, "R8 lane_mismatch", lane_mismatch, e_mm);
        end
        if (byte_valid === 1'b1) begin rxq.push_back(byte_data); bv_cnt++; end
        if (done === 1'b1) begin done_cnt++; got_mm = lane_mismatch; got_err = crc_err; end
    end

    task automatic drive(input logic [3:0] n, input int gap);
        @(negedge clk);
        dat_strobe = 1'b1;
        dat_in = n;
        repeat (gap) begin
            @(negedge clk);
            dat_strobe = 1'b0;
            dat_in = 4'($urandom);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        dat_strobe = 1'b1;
        dat_in = 4'h0;
        @(negedge clk);
        start = 1'b0;
        dat_strobe = 1'b0;
        dat_in = 4'hF;
    endtask

    task automatic send_block(input int gap, input logic [3:0] bad, input int pre);
        logic [15:0] rc [4];
        logic [3:0]  nb;
        for (int k = 0; k < 4; k++) rc[k] = lane_ref(k);
        pulse_start();
        rxq.delete();
        repeat (pre) drive(4'hF, gap);
        drive(4'h0, gap);
        for (int i = 0; i < NB; i++) begin
            drive(pay[i][7:4], gap);
            drive(pay[i][3:0], gap);
        end
        for (int j = 15; j >= 0; j--) begin
            for (int k = 0; k < 4; k++) nb[k] = rc[k][j] ^ (bad[k] && j == 5);
            drive(nb, gap);
        end
        drive(4'($urandom), gap);
        @(negedge clk);
        dat_strobe = 1'b0;
        dat_in = 4'hF;
        repeat (3) @(negedge clk);
    endtask

    task automatic verify_block(input logic [3:0] bad, input int done_before, input string tag);
        int diffs = 0;
        check(done_cnt == done_before + 1, {tag, " R7 one done per block"}, done_cnt, done_before + 1);
        check(rxq.size() == NB, {tag, " R4 byte count"}, rxq.size(), NB);
        for (int i = 0; i < NB && i < rxq.size(); i++) if (rxq[i] !== pay[i]) diffs++;
        check(diffs == 0, {tag, " R4 byte order and value"}, diffs, 0);
        check(got_mm == bad, {tag, " R5 R6 R8 lane mismatch"}, got_mm, bad);
        check(got_err == |bad, {tag, " R8 block error"}, got_err, |bad);
    endtask

    task automatic idle_strobes(input int n, input string tag);
        int b0 = bv_cnt;
        int d0 = done_cnt;
        repeat (n) drive(4'h0, 0);
        @(negedge clk); dat_strobe = 1'b0;
        repeat (2) @(negedge clk);
        check(bv_cnt == b0, {tag, " no bytes while idle"}, bv_cnt, b0);
        check(done_cnt == d0, {tag, " no done while idle"}, done_cnt, d0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(done === 1'b0 && byte_valid === 1'b0, "R1 reset pulses low", {done, byte_valid}, 0);
        check(crc_err === 1'b0 && lane_mismatch === 4'h0, "R1 reset status clear", {crc_err, lane_mismatch}, 0);
        idle_strobes(20, "R1");

        // R5 R6: clean block, random payload, back-to-back strobes, preamble with DAT0 high (R3)
        for (int i = 0; i < NB; i++) pay[i] = 8'($urandom);
        d = done_cnt;
        send_block(0, 4'h0, 5);
        verify_block(4'h0, d, "clean");

        // R9: strobes after done are ignored
        idle_strobes(10, "R9");

        // R8: lane 2 corrupted
        d = done_cnt;
        send_block(0, 4'b0100, 0);
        verify_block(4'b0100, d, "lane2");
        repeat (20) @(negedge clk);
        check(lane_mismatch === 4'b0100 && crc_err === 1'b1, "R8 status held after done", lane_mismatch, 4'b0100);
        pulse_start();
        check(lane_mismatch === 4'h0 && crc_err === 1'b0, "R2 start clears status", lane_mismatch, 0);

        // R9: retry after error passes
        d = done_cnt;
        send_block(0, 4'h0, 1);
        verify_block(4'h0, d, "R9 retry");

        // R7: gapped strobes, alternating 00/FF, every lane corrupted
        for (int i = 0; i < NB; i++) pay[i] = (i % 2) ? 8'hFF : 8'h00;
        d = done_cnt;
        send_block(2, 4'hF, 2);
        verify_block(4'hF, d, "R7 gapped");

        // R2: abandon mid-payload, then a full block of incrementing bytes
        for (int i = 0; i < NB; i++) pay[i] = 8'(i);
        pulse_start();
        drive(4'h0, 0);
        for (int i = 0; i < 100; i++) drive(4'(i), 0);
        d = done_cnt;
        send_block(1, 4'b1001, 0);
        verify_block(4'b1001, d, "R2 restart");

        // R5: zero payload gives zero CRC on each lane
        for (int i = 0; i < NB; i++) pay[i] = 8'h00;
        check(lane_ref(0) == 16'h0000, "R5 zero payload CRC", lane_ref(0), 0);
        d = done_cnt;
        send_block(0, 4'b0001, 0);
        verify_block(4'b0001, d, "R5 zero");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule